// File: doc/BRIEF.md
# Timestamp-LRU Four-Slot Fully-Associative Lookup Cache

This block tracks which addresses are resident in a small fully-associative cache whose every slot holds a single address. Each lookup request is compared against all valid slots in parallel. The block answers hit or miss and reports the slot that was used. On a hit, that slot is the matching one. On a miss, it is the slot that was filled, and the new address is installed as its tag.

Recency is kept with timestamps. A shared access clock advances once per accepted lookup, and the new count is written into the stamp of the slot that was touched. On a miss, an empty slot is used if one exists. Otherwise the valid slot with the oldest (smallest) stamp is evicted. A flush input empties the cache and restarts the clock.

Responses are registered. They appear on the cycle after the request and last one cycle. A debug view of every slot's tag and valid bit is always visible.

Top module: `ts_lru_cache`

## Requirements
- R1: While reset is low, and on the first cycle after it, every slot is invalid and both `hit` and `miss` are low.
- R2: A request accepted on one clock edge (`req_valid` high, `flush` low) raises exactly one of `hit` or `miss` after that edge, for one cycle. After an edge with no accepted request, both are low.
- R3: A request whose address equals the tag of a valid slot is a hit. `slot_idx` then gives that slot, and no tag or valid bit changes.
- R4: On a miss while any slot is invalid, the lowest-numbered invalid slot receives the address and becomes valid, and `slot_idx` names it.
- R5: Every accepted request adds one to the access clock and stores the new count in the touched slot's stamp. On a miss with all slots valid, the slot with the smallest stamp is replaced.
- R6: When several valid slots share the smallest stamp, the lowest-numbered of them is replaced.
- R7: A request made while the access clock holds its maximum value wraps the clock to zero and clears every slot's stamp. The touched slot then takes the value zero.
- R8: `flush` clears all valid bits and restarts the access clock at zero. A request made in the same cycle as `flush` is dropped, so neither `hit` nor `miss` follows and no slot is filled.
- R9: `tag_view` bits `[i*ADDR_W +: ADDR_W]` hold slot i's tag, and `valid_view` bit i is its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty all slots and restart the access clock |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Address to look up |
| hit | output | 1 | Registered: previous request hit |
| miss | output | 1 | Registered: previous request missed |
| slot_idx | output | log2(NUM_SLOTS) | Registered: slot hit or filled |
| tag_view | output | NUM_SLOTS*ADDR_W | Debug view of all tags |
| valid_view | output | NUM_SLOTS | Debug view of all valid bits |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is flush and lookup. The bench raises `flush` and `req_valid` together for an address that would otherwise be filled. It then judges the result at the ports: no response must follow, the valid view must be empty, and a later lookup of that address must miss into slot 0.

The second pair is clock wrap and victim choice. With a narrow stamp, the bench drives the clock to its maximum and makes one more hit. It then checks that the next two misses take slot 0 and then slot 1. Age order alone would have chosen other slots, so the checks show that all stamps were cleared and that ties go to the lowest index.

// File: rtl/ts_lru_pkg.sv
// Shared types for the timestamp-LRU cache.
package ts_lru_pkg;
    // Registered response kind of one lookup
    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_HIT  = 2'd1,
        RESP_MISS = 2'd2
    } resp_e;
endpackage

// File: rtl/tag_match.sv
// Parallel tag compare across all slots.
// Assumes tags are packed slot-major in tags_i; returns the lowest matching valid slot.
module tag_match #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*ADDR_W-1:0] tags_i,
    input  logic [NUM_SLOTS-1:0]        valid_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic                        hit_o,
    output logic [IDX_W-1:0]            idx_o
);
    // Priority scan for the first valid slot whose tag equals the address
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!hit_o && valid_i[i] && tags_i[i*ADDR_W +: ADDR_W] == addr_i) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/victim_select.sv
// Chooses the slot to fill on a miss.
// Assumes stamps are packed slot-major; an invalid slot (lowest first) beats any valid one,
// otherwise the smallest stamp wins with ties going to the lower index.
module victim_select #(
    parameter int NUM_SLOTS = 4,
    parameter int STAMP_W   = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]         valid_i,
    input  logic [NUM_SLOTS*STAMP_W-1:0] stamps_i,
    output logic [IDX_W-1:0]             idx_o
);
    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;
    logic [STAMP_W-1:0] old_stamp;

    // Find the lowest-numbered empty slot
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!have_free && !valid_i[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    // Linear minimum search over stamps, strict compare keeps the lower index on ties
    always_comb begin
        old_idx   = '0;
        old_stamp = stamps_i[0 +: STAMP_W];
        for (int i = 1; i < NUM_SLOTS; i++) begin
            if (stamps_i[i*STAMP_W +: STAMP_W] < old_stamp) begin
                old_stamp = stamps_i[i*STAMP_W +: STAMP_W];
                old_idx   = IDX_W'(i);
            end
        end
    end

    // Empty slot first, oldest slot otherwise
    always_comb idx_o = have_free ? free_idx : old_idx;
endmodule

// File: rtl/access_clock.sv
// Shared access counter that feeds the per-slot stamps.
// Assumes advance_i pulses once per accepted lookup; clear_i has priority.
module access_clock #(
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               advance_i,
    output logic [STAMP_W-1:0] next_o,
    output logic               wrap_o
);
    logic [STAMP_W-1:0] count_q;

    // Value the counter takes on this access, and whether it rolls over
    always_comb begin
        next_o = count_q + STAMP_W'(1);
        wrap_o = advance_i && (count_q == {STAMP_W{1'b1}});
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)         count_q <= '0;
        else if (clear_i)   count_q <= '0;
        else if (advance_i) count_q <= next_o;
    end
endmodule

// File: rtl/ts_lru_cache.sv
// Fully-associative single-address-per-slot cache with timestamp LRU.
// Assumes NUM_SLOTS >= 2. One lookup per cycle; response registered one cycle later.
module ts_lru_cache
    import ts_lru_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 16,
    parameter int STAMP_W   = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        hit,
    output logic                        miss,
    output logic [IDX_W-1:0]            slot_idx,
    output logic [NUM_SLOTS*ADDR_W-1:0] tag_view,
    output logic [NUM_SLOTS-1:0]        valid_view
);
    logic [NUM_SLOTS*ADDR_W-1:0]  tag_q;
    logic [NUM_SLOTS*STAMP_W-1:0] stamp_q;
    logic [NUM_SLOTS-1:0]         valid_q;
    logic                         accept;
    logic                         lookup_hit;
    logic [IDX_W-1:0]             hit_idx;
    logic [IDX_W-1:0]             victim_idx;
    logic [IDX_W-1:0]             target_idx;
    logic [STAMP_W-1:0]           count_next;
    logic                         count_wrap;
    resp_e                        resp_q;
    logic [IDX_W-1:0]             slot_q;

    // A request is taken only when no flush competes with it
    always_comb accept = req_valid && !flush;

    tag_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_match (
        .tags_i  (tag_q),
        .valid_i (valid_q),
        .addr_i  (req_addr),
        .hit_o   (lookup_hit),
        .idx_o   (hit_idx)
    );

    victim_select #(.NUM_SLOTS(NUM_SLOTS), .STAMP_W(STAMP_W)) u_victim (
        .valid_i  (valid_q),
        .stamps_i (stamp_q),
        .idx_o    (victim_idx)
    );

    access_clock #(.STAMP_W(STAMP_W)) u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush),
        .advance_i (accept),
        .next_o    (count_next),
        .wrap_o    (count_wrap)
    );

    // Slot touched by this request
    always_comb target_idx = lookup_hit ? hit_idx : victim_idx;

    // Slot state: tags, valid bits and recency stamps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            stamp_q <= '0;
            valid_q <= '0;
        end else if (flush) begin
            stamp_q <= '0;
            valid_q <= '0;
        end else if (accept) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (count_wrap)
                    stamp_q[i*STAMP_W +: STAMP_W] <= '0;
                if (IDX_W'(i) == target_idx) begin
                    stamp_q[i*STAMP_W +: STAMP_W] <= count_next;
                    if (!lookup_hit) begin
                        tag_q[i*ADDR_W +: ADDR_W] <= req_addr;
                        valid_q[i]                <= 1'b1;
                    end
                end
            end
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= RESP_NONE;
            slot_q <= '0;
        end else begin
            resp_q <= !accept ? RESP_NONE : (lookup_hit ? RESP_HIT : RESP_MISS);
            if (accept) slot_q <= target_idx;
        end
    end

    // Output mapping
    always_comb begin
        hit        = (resp_q == RESP_HIT);
        miss       = (resp_q == RESP_MISS);
        slot_idx   = slot_q;
        tag_view   = tag_q;
        valid_view = valid_q;
    end
endmodule

// File: rtl/ts_lru_cache_chk.sv
// Port-level temporal checks for ts_lru_cache, bound to every instance.
module ts_lru_cache_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        flush,
    input logic                        req_valid,
    input logic [ADDR_W-1:0]           req_addr,
    input logic                        hit,
    input logic                        miss,
    input logic [IDX_W-1:0]            slot_idx,
    input logic [NUM_SLOTS*ADDR_W-1:0] tag_view,
    input logic [NUM_SLOTS-1:0]        valid_view
);
    // R2
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));
    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flush) |=> (hit || miss));
    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !flush) |=> !(hit || miss));
    // R3
    hit_keeps_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (tag_view == $past(tag_view)) && (valid_view == $past(valid_view)));
    // R4
    miss_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> valid_view[slot_idx] && (tag_view[slot_idx*ADDR_W +: ADDR_W] == $past(req_addr)));
    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_view == '0));
endmodule

bind ts_lru_cache ts_lru_cache_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit), .miss(miss), .slot_idx(slot_idx), .tag_view(tag_view), .valid_view(valid_view)
);

// File: tb/ts_lru_cache_tb.sv
// Self-checking bench: vector table walk, then flush, wrap and tie corner cases.
module ts_lru_cache_tb;
    localparam int NS = 4;
    localparam int AW = 16;
    localparam int SW = 4;   // narrow stamp so the wrap is reachable quickly

    typedef struct packed {
        logic [15:0] addr;
        logic        exp_hit;
        logic [1:0]  exp_slot;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{16'h0012, 1'b0, 2'd0}, '{16'h0014, 1'b0, 2'd1},
        '{16'h0016, 1'b0, 2'd2}, '{16'h0018, 1'b0, 2'd3},
        '{16'h0016, 1'b1, 2'd2}, '{16'h0012, 1'b1, 2'd0},
        '{16'h0020, 1'b0, 2'd1}, '{16'h0022, 1'b0, 2'd3},
        '{16'h0014, 1'b0, 2'd2}, '{16'h0012, 1'b1, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          hit, miss;
    logic [1:0]    slot_idx;
    logic [NS*AW-1:0] tag_view;
    logic [NS-1:0] valid_view;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ts_lru_cache #(.NUM_SLOTS(NS), .ADDR_W(AW), .STAMP_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
        .hit(hit), .miss(miss), .slot_idx(slot_idx), .tag_view(tag_view), .valid_view(valid_view)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One lookup; response is sampled at the following falling edge
    task automatic lookup(input logic [15:0] a, input logic exp_hit, input logic [1:0] exp_slot,
                          input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " hit"},  64'(hit),  64'(exp_hit));
        check({req, " miss"}, 64'(miss), 64'(!exp_hit));
        check({req, " slot"}, 64'(slot_idx), 64'(exp_slot));
        if (!exp_hit)
            check({req, " tag"}, 64'(tag_view[exp_slot*AW +: AW]), 64'(a));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 hit", 64'(hit), 0);
        check("R1 miss", 64'(miss), 0);
        check("R1 valid", 64'(valid_view), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", 64'(valid_view), 0);

        // R3 R4 R5 table walk
        for (int k = 0; k < 10; k++)
            lookup(VECS[k].addr, VECS[k].exp_hit, VECS[k].exp_slot, "R5 table");

        // R2 idle cycle gives no response
        @(negedge clk);
        check("R2 idle hit", 64'(hit), 0);
        check("R2 idle miss", 64'(miss), 0);

        // R9 debug view layout
        check("R9 slot0", 64'(tag_view[0*AW +: AW]), 64'h12);
        check("R9 slot1", 64'(tag_view[1*AW +: AW]), 64'h20);
        check("R9 slot2", 64'(tag_view[2*AW +: AW]), 64'h14);
        check("R9 slot3", 64'(tag_view[3*AW +: AW]), 64'h22);
        check("R9 valid", 64'(valid_view), 64'hF);

        // R8 flush empties the cache
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        check("R8 flush valid", 64'(valid_view), 0);
        lookup(16'h0012, 1'b0, 2'd0, "R8 R4 refill after flush");
        lookup(16'h0030, 1'b0, 2'd1, "R4 fill");
        lookup(16'h0040, 1'b0, 2'd2, "R4 fill");
        lookup(16'h0050, 1'b0, 2'd3, "R4 fill");
        // clock now 4; raise it to 15 with hits on slot 0
        for (int k = 0; k < 11; k++)
            lookup(16'h0012, 1'b1, 2'd0, "R3 repeat hit");
        lookup(16'h0030, 1'b1, 2'd1, "R7 wrapping hit");
        lookup(16'h0060, 1'b0, 2'd0, "R7 stamps cleared on wrap");
        lookup(16'h0070, 1'b0, 2'd1, "R6 tie lower index");

        // R8 flush and request in the same cycle
        @(negedge clk);
        flush = 1'b1; req_valid = 1'b1; req_addr = 16'h0099;
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0;
        check("R8 dropped hit", 64'(hit), 0);
        check("R8 dropped miss", 64'(miss), 0);
        check("R8 dropped valid", 64'(valid_view), 0);
        lookup(16'h0099, 1'b0, 2'd0, "R8 dropped request not filled");
        lookup(16'h0099, 1'b1, 2'd0, "R3 hit after refill");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule